// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase

This block generates the common counting base that a group of PWM channels compares against. It picks one of two single-cycle tick inputs as its source and divides that source by a fixed-point ratio that has 8 fractional bits. The divided ticks advance a counter whose period is a programmable power of two. When the counter returns to zero, the block raises an overflow pulse. The channels read the counter value and the pulse and do their own comparing. A single 32-bit configuration word, written through a plain write-enable port, sets the block up.

Divisor and resolution are staged. A write stores them, but the running timer keeps its old working values until the write also carries the apply bit. The staged values then take effect at the next counter wrap, so the PWM period in progress always completes. If the counter is being held clear at that moment, they take effect at once.

A small controller has three named states. CLEARED holds the counter and divider at zero. RUNNING lets divided ticks advance the counter. HOLDING freezes the counter and the divider. The controller moves on the clock edge after the configuration word changes. If the clear bit is set, it goes to CLEARED. Otherwise, if the halt bit is set, it goes to HOLDING. Otherwise it goes to RUNNING. Any state can reach any other state directly through these transitions.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter and the overflow output are 0. The stored configuration equals 0x0100_0000, so only the clear bit is set, and the counter stays at 0 until software writes the configuration.
- R2: The configuration word has these fields. Bits [7:0] hold the divisor's fractional part. Bits [17:8] hold its integer part. Bits [22:18] hold the resolution. Bit 23 is halt, bit 24 is clear, bit 25 is source select and bit 26 is apply. Bits 31:27 are ignored.
- R3: When source select is 1, the slow tick input is the source. When it is 0, the reference tick input is the source. The select takes effect from the edge at which the write is stored.
- R4: The divider emits one divided tick every I source ticks, where I is the integer part. On each divided tick an 8-bit accumulator adds the fractional part. When that add carries out, the next period lasts I+1 source ticks.
- R5: An integer part of 0 behaves as 1, so a divided tick never comes more often than the source tick.
- R6: The counter steps 0, 1, …, 2^R−1 and then returns to 0, where R is the working resolution, limited to 20. The overflow output is high for one cycle, namely the cycle in which the counter has just returned to 0.
- R7: While the controller is HOLDING, the counter, the divider phase and the accumulator do not change.
- R8: While the controller is CLEARED, the counter, the divider phase and the accumulator are forced to 0. Clear wins over halt.
- R9: The apply bit is not stored. It leaves a request pending. In RUNNING, the request copies the staged divisor and resolution into the working values at the edge where the counter wraps. That edge also restarts the divider with an empty accumulator. Until then the old period and ratio stay in force.
- R10: A pending request is served at once while the controller is CLEARED.
- R11: The controller state follows a configuration write on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word |
| slow_tick | input | 1 | Slow source tick, one cycle wide |
| ref_tick | input | 1 | Reference source tick, one cycle wide |
| count | output | CNT_W | Current timebase value |
| ovf | output | 1 | One-cycle pulse when the counter returns to 0 |

## Verification
The assertions assume three things about the inputs: both tick inputs are synchronous to clk, each tick is one cycle wide, and configuration writes are ordinary synchronous strobes. The bench drives every input on the falling edge from fixed modular patterns, and it writes the configuration only through one-cycle strobes. The bench holds the sequence in which the integer part is zero and apply requests land in CLEARED, HOLDING and mid-period RUNNING, against a behavioural model that is compared with both outputs on every cycle.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    localparam int FRAC_W    = 8;
    localparam int INT_W     = 10;
    localparam int RES_W     = 5;
    localparam int FRAC_LSB  = 0;
    localparam int INT_LSB   = FRAC_LSB + FRAC_W;
    localparam int RES_LSB   = INT_LSB + INT_W;
    localparam int HALT_BIT  = RES_LSB + RES_W;
    localparam int CLR_BIT   = HALT_BIT + 1;
    localparam int SEL_BIT   = CLR_BIT + 1;
    localparam int APPLY_BIT = SEL_BIT + 1;

    typedef enum logic [1:0] {
        ST_CLEARED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_HOLDING = 2'd2
    } tb_state_e;
endpackage

// File: rtl/ptb_cfg_regs.sv
module ptb_cfg_regs
    import ptb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [31:0]       wdata,
    input  logic              apply_now,
    output logic              halt,
    output logic              clr,
    output logic              sel,
    output logic              pending,
    output logic [INT_W-1:0]  stage_int,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic [RES_W-1:0]  act_res
);
    logic [FRAC_W-1:0] stage_frac;
    logic [RES_W-1:0]  stage_res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt       <= 1'b0;
            clr        <= 1'b1;
            sel        <= 1'b0;
            stage_int  <= '0;
            stage_frac <= '0;
            stage_res  <= '0;
        end else if (we) begin
            halt       <= wdata[HALT_BIT];
            clr        <= wdata[CLR_BIT];
            sel        <= wdata[SEL_BIT];
            stage_int  <= wdata[INT_LSB +: INT_W];
            stage_frac <= wdata[FRAC_LSB +: FRAC_W];
            stage_res  <= wdata[RES_LSB +: RES_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (we && wdata[APPLY_BIT]) begin
            pending <= 1'b1;
        end else if (apply_now) begin
            pending <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_int  <= '0;
            act_frac <= '0;
            act_res  <= '0;
        end else if (apply_now) begin
            act_int  <= stage_int;
            act_frac <= stage_frac;
            act_res  <= stage_res;
        end
    end

    // R9
    act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_now |=> ($stable(act_res) && $stable(act_int) && $stable(act_frac)));
endmodule

// File: rtl/ptb_frac_div.sv
module ptb_frac_div
    import ptb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic              reload,
    input  logic              src,
    input  logic [INT_W-1:0]  load_int,
    input  logic [FRAC_W-1:0] frac,
    output logic              div_tick
);
    localparam int PL_W = INT_W + 1;

    logic [PL_W-1:0]   tc;
    logic [PL_W-1:0]   plen;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    function automatic logic [PL_W-1:0] eff(input logic [INT_W-1:0] v);
        eff = (v == '0) ? PL_W'(1) : {1'b0, v};
    endfunction

    assign div_tick = run && src && (tc == plen - PL_W'(1));
    assign sum      = {1'b0, acc} + {1'b0, frac};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc   <= '0;
            acc  <= '0;
            plen <= PL_W'(1);
        end else if (clr || reload) begin
            tc   <= '0;
            acc  <= '0;
            plen <= eff(load_int);
        end else if (run && src) begin
            if (div_tick) begin
                tc   <= '0;
                acc  <= sum[FRAC_W-1:0];
                plen <= eff(load_int) + PL_W'(sum[FRAC_W]);
            end else begin
                tc <= tc + PL_W'(1);
            end
        end
    end

    // R4
    tc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) tc < plen);
    // R5
    plen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) plen != '0);
    // R7
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr && !reload) |=> ($stable(tc) && $stable(acc)));
endmodule

// File: rtl/ptb_count.sv
module ptb_count
    import ptb_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [RES_W-1:0] res,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             ovf
);
    localparam logic [RES_W-1:0] RES_CAP = RES_W'(CNT_W);

    logic [RES_W-1:0] res_c;
    logic [CNT_W-1:0] max_v;

    assign res_c = (res > RES_CAP) ? RES_CAP : res;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            max_v[i] = (i < int'(res_c));
        end
    end

    assign wrap = tick && (count == max_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= wrap && !clr;
            if (clr || wrap) begin
                count <= '0;
            end else if (tick) begin
                count <= count + CNT_W'(1);
            end
        end
    end

    // R6
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> (count == '0));
    // R6
    count_max_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= max_v);
    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (count == '0));
endmodule

// File: rtl/ptb_ctrl.sv
module ptb_ctrl
    import ptb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_cfg,
    input  logic      halt_cfg,
    input  logic      pending,
    input  logic      wrap,
    output tb_state_e state,
    output logic      run,
    output logic      clr_st,
    output logic      apply_now
);
    tb_state_e state_d;

    always_comb begin
        if (clr_cfg) begin
            state_d = ST_CLEARED;
        end else if (halt_cfg) begin
            state_d = ST_HOLDING;
        end else begin
            state_d = ST_RUNNING;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEARED;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        run       = 1'b0;
        clr_st    = 1'b0;
        apply_now = 1'b0;
        unique case (state)
            ST_CLEARED: begin
                clr_st    = 1'b1;
                apply_now = pending;
            end
            ST_RUNNING: begin
                run       = 1'b1;
                apply_now = pending && wrap;
            end
            ST_HOLDING: begin
            end
            default: begin
                clr_st = 1'b1;
            end
        endcase
    end

    // R11
    clear_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cfg |=> (state == ST_CLEARED));
    // R11
    hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cfg && halt_cfg) |=> (state == ST_HOLDING));
    // R10
    clear_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEARED && pending) |-> apply_now);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             slow_tick,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic              halt_cfg, clr_cfg, sel_cfg, pending;
    logic [INT_W-1:0]  stage_int, act_int, load_int;
    logic [FRAC_W-1:0] act_frac;
    logic [RES_W-1:0]  act_res;
    logic              run, clr_st, apply_now, wrap, div_tick, src;
    tb_state_e         state;

    assign src      = sel_cfg ? slow_tick : ref_tick;
    assign load_int = apply_now ? stage_int : act_int;

    ptb_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .apply_now(apply_now), .halt(halt_cfg), .clr(clr_cfg), .sel(sel_cfg),
        .pending(pending), .stage_int(stage_int), .act_int(act_int),
        .act_frac(act_frac), .act_res(act_res)
    );

    ptb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_cfg(clr_cfg), .halt_cfg(halt_cfg),
        .pending(pending), .wrap(wrap), .state(state), .run(run),
        .clr_st(clr_st), .apply_now(apply_now)
    );

    ptb_frac_div u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_st), .reload(apply_now),
        .src(src), .load_int(load_int), .frac(act_frac), .div_tick(div_tick)
    );

    ptb_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_st), .tick(div_tick),
        .res(act_res), .count(count), .wrap(wrap), .ovf(ovf)
    );

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLDING) |=> ($stable(count) && !ovf));
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
    localparam int PERIOD = 10;
    localparam int CNT_W  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic             slow_tick = 1'b0;
    logic             ref_tick = 1'b0;
    logic [CNT_W-1:0] count;
    logic             ovf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_clr, m_halt, m_sel, m_sint, m_sfrac, m_sres;
    int m_aint, m_afrac, m_ares, m_pend, m_st;
    int m_tc, m_acc, m_plen, m_cnt, m_ovf;

    pwm_timebase #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .slow_tick(slow_tick), .ref_tick(ref_tick), .count(count), .ovf(ovf)
    );

    always #(PERIOD / 2) clk = ~clk;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [31:0] word(input int ip, input int fp, input int res,
                                         input int halt, input int clr, input int sel,
                                         input int apply);
        // R2 layout: frac [7:0], int [17:8], res [22:18], halt 23, clear 24, select 25, apply 26
        return 32'(fp & 255) | (32'(ip & 1023) << 8) | (32'(res & 31) << 18) |
               (32'(halt & 1) << 23) | (32'(clr & 1) << 24) | (32'(sel & 1) << 25) |
               (32'(apply & 1) << 26);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clr = 1; m_halt = 0; m_sel = 0; m_sint = 0; m_sfrac = 0; m_sres = 0;
            m_aint = 0; m_afrac = 0; m_ares = 0; m_pend = 0; m_st = 0;
            m_tc = 0; m_acc = 0; m_plen = 1; m_cnt = 0; m_ovf = 0;
        end else begin
            int src, maxv, app, nov, nst, s;
            src  = m_sel ? int'(slow_tick) : int'(ref_tick);
            maxv = (1 << ((m_ares > 20) ? 20 : m_ares)) - 1;
            app  = 0;
            nov  = 0;
            nst  = m_clr ? 0 : (m_halt ? 2 : 1);
            if (m_st == 0) begin
                app    = m_pend;
                m_tc   = 0;
                m_acc  = 0;
                m_plen = eff(app ? m_sint : m_aint);
                m_cnt  = 0;
            end else if (m_st == 1 && src != 0) begin
                if (m_tc == m_plen - 1) begin
                    m_tc = 0;
                    if (m_cnt == maxv) begin
                        app   = m_pend;
                        m_cnt = 0;
                        nov   = 1;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                    if (app != 0) begin
                        m_acc  = 0;
                        m_plen = eff(m_sint);
                    end else begin
                        s      = m_acc + m_afrac;
                        m_acc  = s & 255;
                        m_plen = eff(m_aint) + (s >> 8);
                    end
                end else begin
                    m_tc = m_tc + 1;
                end
            end
            if (app != 0) begin
                m_aint = m_sint; m_afrac = m_sfrac; m_ares = m_sres; m_pend = 0;
            end
            m_ovf = nov;
            if (cfg_we) begin
                m_sfrac = int'(cfg_wdata[7:0]);
                m_sint  = int'(cfg_wdata[17:8]);
                m_sres  = int'(cfg_wdata[22:18]);
                m_halt  = int'(cfg_wdata[23]);
                m_clr   = int'(cfg_wdata[24]);
                m_sel   = int'(cfg_wdata[25]);
                if (cfg_wdata[26]) m_pend = 1;
            end
            m_st = nst;
        end
    end

    always @(posedge clk) begin
        #(PERIOD / 4);
        cyc = cyc + 1;
        if (rst_n) begin
            n_chk = n_chk + 1;
            if (int'(count) != m_cnt || int'(ovf) != m_ovf) begin
                n_fail = n_fail + 1;
                $display("FAIL %s cycle %0d: count=%0d ovf=%0d expected count=%0d ovf=%0d",
                         cur_req, cyc, count, ovf, m_cnt, m_ovf);
            end
        end
    end

    always @(negedge clk) begin
        ref_tick  <= (cyc % 3) == 0;
        slow_tick <= ((cyc % 5) == 1) || ((cyc % 11) == 0);
    end

    task automatic check(input string req, input int got, input int exp);
        n_chk = n_chk + 1;
        if (got != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int mx;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 count after reset", int'(count), 0);
        check("R1 ovf after reset", int'(ovf), 0);
        idle(20);
        check("R1 held clear by default word", int'(count), 0);

        cur_req = "R10";
        wr(word(1, 0, 2, 0, 1, 0, 1));
        cur_req = "R11";
        wr(word(1, 0, 2, 0, 0, 0, 0));
        cur_req = "R6";
        idle(60);

        cur_req = "R9";
        wr(word(2, 128, 3, 0, 0, 0, 1));
        mx = 0;
        for (int i = 0; i < 200 && !ovf; i++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        check("R9 old range kept until wrap", mx, 3);
        mx = 0;
        @(negedge clk);
        for (int i = 0; i < 400 && !ovf; i++) begin
            @(negedge clk);
            if (int'(count) > mx) mx = int'(count);
        end
        cur_req = "R4";
        check("R6 new range after wrap", mx, 7);
        idle(100);

        cur_req = "R7";
        wr(word(2, 128, 3, 1, 0, 0, 0));
        idle(3);
        mx = int'(count);
        idle(30);
        check("R7 count frozen while holding", int'(count), mx);
        wr(word(2, 128, 3, 0, 0, 0, 0));
        idle(50);

        cur_req = "R8";
        wr(word(2, 128, 3, 1, 1, 0, 0));
        idle(3);
        check("R8 clear beats halt", int'(count), 0);
        idle(7);

        cur_req = "R5";
        wr(word(0, 64, 1, 0, 1, 1, 1));
        cur_req = "R3";
        wr(word(0, 64, 1, 0, 0, 1, 0));
        idle(150);

        cur_req = "R2";
        wr(word(1, 0, 25, 0, 0, 1, 1) | 32'hF800_0000);
        idle(200);

        cur_req = "R4";
        wr(word(3, 255, 0, 0, 1, 0, 1));
        wr(word(3, 255, 0, 0, 0, 0, 0));
        idle(200);

        cur_req = "R9";
        wr(word(1, 0, 2, 1, 0, 0, 1));
        idle(20);
        wr(word(1, 0, 2, 0, 0, 0, 0));
        idle(150);

        finish_run();
    end
endmodule